// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single 32-bit timer channel behind a small word-register interface. A counter steps down once per prescaled tick. The tick is taken from the peripheral clock through a divider that can be set to 4, 16, 64, 256 or 1024. When a tick finds the counter at zero, the counter reloads from a constant register and a sticky underflow flag is set. While its enable bit is on, that flag holds a level interrupt high.

The parent timer unit drives a run input. When the input is low, both the count and the prescaler freeze. Software uses the register port for four things:
- setting the reload constant;
- loading the counter directly;
- programming the divider and interrupt enable;
- clearing the flag, which is done by writing zero to its bit.

The clock-edge and capture-enable control fields are kept only as stored values. A write that puts a reserved code into a field does not change that field, and it raises a sticky configuration-error output.

Top module: `rld_timer_chan`

## Requirements
- R1: After reset the constant (byte offset 0x0) and count (0x4) registers read 0xFFFFFFFF, the control register (0x8) and capture register (0xC) read 0, and irqOut and cfgErr are 0.
- R2: Control bits [2:0] pick the divider. Codes 0, 1, 2, 3 and 4 give one count step every 4, 16, 64, 256 and 1024 clock cycles of runEn high. Every control write restarts the divider from zero.
- R3: A tick that finds the count at 0 loads the constant into the counter and sets the underflow flag at the same clock edge. Any other tick decrements the count by 1.
- R4: A write to offset 0x0 changes only the reload constant and leaves the count as it was. A write to 0x4 loads the counter on that clock edge, and it takes priority over a tick in the same cycle.
- R5: While runEn is 0 the count and the divider phase hold their values, and no underflow occurs.
- R6: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag unchanged, and a register write never sets it.
- R7: irqOut is 1 exactly when the underflow flag is 1 and control bit 5 (interrupt enable) is 1.
- R8: A control read returns the stored bits [7:0] (divider [2:0], edge select [4:3], interrupt enable [5], capture enable [7:6]) with the live flag in bit 8. Bit 9 and bits [31:10] read as 0.
- R9: In a control write, the following are ignored and set cfgErr, which stays set until reset:
  - a divider code of 5, or of 6 or 7 without the external-clock option (EXTCLK_EN = 0);
  - a nonzero edge select without that option;
  - a capture-enable code of 1, or any nonzero capture-enable code without the capture option;
  - bit 9 set without the capture option;
  - any of bits [31:10] set.

  The legal fields of the same write still take effect. A write to 0xC without the capture option also sets cfgErr.
- R10: With the capture option (CAPTURE_EN = 1, the default), offset 0xC is a read/write word register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run input from the parent unit; 0 freezes the count |
| busAddr | input | 4 | Byte address of the word register |
| busWe | input | 1 | Write strobe, one write per cycle it is high |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Level underflow interrupt |
| cfgErr | output | 1 | Sticky reserved-field error |

## Verification
Several properties are checked on every clock edge:
- the step-by-one decrement;
- the reload on a tick at zero, with the flag set in the same edge;
- a count write taking effect;
- the freeze while runEn is low;
- the flag clearing on a bit-8-zero write and never rising without a tick;
- the stickiness of cfgErr.

The exact divider periods, the way reserved fields are stripped from a mixed write, the composition of the control read and the interrupt gating can only be shown by the bench scenarios. In those scenarios a behavioural reference model is compared against the read data and the outputs on every cycle, alongside directed checks.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int PSC_LAST = 4;                    // highest internal divider code
  localparam int PRE_W    = 2 * (PSC_LAST + 1);   // holds 4^(PSC_LAST+1)-1

  typedef enum logic [1:0] {
    REG_CONST = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CAPT  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldConst;
    logic ldCount;
    logic ldCtrl;
    logic ldCapt;
    logic clrFlag;
    logic tick;
  } strobe_t;
endpackage

// File: rtl/rld_timer_ctl.sv
module rld_timer_ctl
  import rld_timer_pkg::*;
#(
  parameter bit CAPTURE_EN = 1'b1,
  parameter bit EXTCLK_EN  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb,
  output logic [2:0]        pscSel,
  output logic [1:0]        edgeSel,
  output logic              irqEn,
  output logic [1:0]        capEn,
  output logic              cfgErr
);

  regSel_e          sel;
  logic             wrCtrl;
  logic             pscOk, edgeOk, capOk, flagBad, resvBad, capWrBad;
  logic             internalClk;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic             tick;

  function automatic logic [PRE_W-1:0] limitFor(input logic [2:0] code);
    int lim;
    lim = (4 << (2 * int'(code))) - 1;
    return lim[PRE_W-1:0];
  endfunction

  assign sel    = regSel_e'(busAddr[3:2]);
  assign wrCtrl = busWe && (sel == REG_CTRL);

  // legality of each control field in the incoming word
  assign pscOk    = (busWdata[2:0] <= 3'(PSC_LAST)) ||
                    (EXTCLK_EN && (busWdata[2:0] >= 3'd6));
  assign edgeOk   = (busWdata[4:3] == 2'd0) || EXTCLK_EN;
  assign capOk    = (busWdata[7:6] == 2'd0) ||
                    (CAPTURE_EN && (busWdata[7:6] >= 2'd2));
  assign flagBad  = busWdata[9] && !CAPTURE_EN;
  assign resvBad  = |busWdata[DATA_W-1:10];
  assign capWrBad = busWe && (sel == REG_CAPT) && !CAPTURE_EN;

  // prescaler: only the internal divider codes produce ticks
  assign internalClk = (pscSel <= 3'(PSC_LAST));
  assign preLim      = limitFor(pscSel);
  assign tick        = runEn && internalClk && !wrCtrl && (preCnt == preLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (wrCtrl) begin
      preCnt <= '0;
    end else if (runEn && internalClk) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscSel  <= '0;
      edgeSel <= '0;
      irqEn   <= 1'b0;
      capEn   <= '0;
    end else if (wrCtrl) begin
      if (pscOk)  pscSel  <= busWdata[2:0];
      if (edgeOk) edgeSel <= busWdata[4:3];
      if (capOk)  capEn   <= busWdata[7:6];
      irqEn <= busWdata[5];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgErr <= 1'b0;
    end else if (capWrBad ||
                 (wrCtrl && (!pscOk || !edgeOk || !capOk || flagBad || resvBad))) begin
      cfgErr <= 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.ldConst = busWe && (sel == REG_CONST);
    strb.ldCount = busWe && (sel == REG_COUNT);
    strb.ldCtrl  = wrCtrl;
    strb.ldCapt  = busWe && (sel == REG_CAPT) && CAPTURE_EN;
    strb.clrFlag = wrCtrl && !busWdata[8];
    strb.tick    = tick;
  end

endmodule

// File: rtl/rld_timer_dp.sv
module rld_timer_dp
  import rld_timer_pkg::*;
#(
  parameter bit CAPTURE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] constVal,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] captVal,
  output logic              uflag
);

  logic atZero;
  assign atZero = (cntVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      constVal <= '1;
    end else if (strb.ldConst) begin
      constVal <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '1;
    end else if (strb.ldCount) begin
      cntVal <= busWdata;
    end else if (strb.tick) begin
      cntVal <= atZero ? constVal : cntVal - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uflag <= 1'b0;
    end else if (strb.tick && atZero && !strb.ldCount) begin
      uflag <= 1'b1;
    end else if (strb.clrFlag) begin
      uflag <= 1'b0;
    end
  end

  generate
    if (CAPTURE_EN) begin : g_capt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          captVal <= '0;
        end else if (strb.ldCapt) begin
          captVal <= busWdata;
        end
      end
    end else begin : g_noCapt
      assign captVal = '0;
    end
  endgenerate

endmodule

// File: rtl/rld_timer_chan.sv
module rld_timer_chan
  import rld_timer_pkg::*;
#(
  parameter bit CAPTURE_EN = 1'b1,
  parameter bit EXTCLK_EN  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              cfgErr
);

  strobe_t           strb;
  logic [2:0]        pscSel;
  logic [1:0]        edgeSel;
  logic              irqEn;
  logic [1:0]        capEn;
  logic [DATA_W-1:0] constVal, cntVal, captVal;
  logic              uflag;

  rld_timer_ctl #(
    .CAPTURE_EN(CAPTURE_EN),
    .EXTCLK_EN (EXTCLK_EN)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strb    (strb),
    .pscSel  (pscSel),
    .edgeSel (edgeSel),
    .irqEn   (irqEn),
    .capEn   (capEn),
    .cfgErr  (cfgErr)
  );

  rld_timer_dp #(
    .CAPTURE_EN(CAPTURE_EN)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .constVal(constVal),
    .cntVal  (cntVal),
    .captVal (captVal),
    .uflag   (uflag)
  );

  always_comb begin
    unique case (regSel_e'(busAddr[3:2]))
      REG_CONST: busRdata = constVal;
      REG_COUNT: busRdata = cntVal;
      REG_CTRL:  busRdata = {{(DATA_W-9){1'b0}}, uflag, capEn, irqEn, edgeSel, pscSel};
      default:   busRdata = captVal;
    endcase
  end

  assign irqOut = uflag && irqEn;

endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk
  import rld_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input strobe_t           strb,
  input logic [DATA_W-1:0] cntVal,
  input logic [DATA_W-1:0] constVal,
  input logic [DATA_W-1:0] busWdata,
  input logic              uflag,
  input logic              cfgErr
);

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.ldCount && cntVal != '0) |=> cntVal == $past(cntVal) - 1);

  a_r3_reload_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.ldCount && cntVal == '0) |=> (cntVal == $past(constVal) && uflag));

  a_r4_count_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldCount |=> cntVal == $past(busWdata));

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !strb.ldCount) |=> $stable(cntVal));

  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !strb.tick) |=> !uflag);

  a_r6_flag_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!uflag && !strb.tick) |=> !uflag);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

endmodule

bind rld_timer_chan rld_timer_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .strb    (strb),
  .cntVal  (cntVal),
  .constVal(constVal),
  .busWdata(busWdata),
  .uflag   (uflag),
  .cfgErr  (cfgErr)
);

// File: tb/rld_timer_chan_tb.sv
module rld_timer_chan_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic [3:0]  bAddr = '0;
  logic        bWe = 1'b0;
  logic [31:0] bWd = '0;
  logic [31:0] rdata;
  logic        irq, err;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rld_timer_chan dut_i (
    .clk(clk), .rstN(rstN), .runEn(run), .busAddr(bAddr), .busWe(bWe),
    .busWdata(bWd), .busRdata(rdata), .irqOut(irq), .cfgErr(err)
  );

  // behavioural reference model (capture present, no external clock)
  logic [31:0] mConst, mCnt, mCap;
  int          mPre;
  logic [2:0]  mPsc;
  logic [1:0]  mEdge, mCapEn;
  logic        mIen, mFlag, mErr;
  logic        mTick, mWrC;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mConst = 32'hFFFF_FFFF; mCnt = 32'hFFFF_FFFF; mCap = 0; mPre = 0;
      mPsc = 0; mEdge = 0; mCapEn = 0; mIen = 0; mFlag = 0; mErr = 0;
    end else begin
      mWrC  = bWe && (bAddr[3:2] == 2'd2);
      mTick = run && (mPsc <= 3'd4) && !mWrC && (mPre == (4 << (2 * int'(mPsc))) - 1);
      if (mWrC) mPre = 0;
      else if (run && mPsc <= 3'd4) mPre = mTick ? 0 : mPre + 1;
      if (bWe && bAddr[3:2] == 2'd1) mCnt = bWd;
      else if (mTick) begin
        if (mCnt == 0) begin mCnt = mConst; mFlag = 1'b1; end
        else mCnt = mCnt - 1;
      end
      if (bWe && bAddr[3:2] == 2'd0) mConst = bWd;
      if (bWe && bAddr[3:2] == 2'd3) mCap = bWd;
      if (mWrC) begin
        if (bWd[2:0] <= 3'd4) mPsc = bWd[2:0]; else mErr = 1'b1;
        if (bWd[4:3] == 0) mEdge = 0; else mErr = 1'b1;
        if (bWd[7:6] == 2'd0 || bWd[7:6] >= 2'd2) mCapEn = bWd[7:6]; else mErr = 1'b1;
        if (bWd[31:10] != 0) mErr = 1'b1;
        mIen = bWd[5];
        if (!bWd[8]) mFlag = 1'b0;
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a[3:2])
      2'd0: return mConst;
      2'd1: return mCnt;
      2'd2: return {23'd0, mFlag, mCapEn, mIen, mEdge, mPsc};
      default: return mCap;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if (rdata !== modelRead(bAddr) || irq !== (mFlag && mIen) || err !== mErr) begin
        fails++;
        $display("FAIL MODEL t=%0t rdata=%h/%h irq=%b/%b err=%b/%b (actual/expected)",
                 $time, rdata, modelRead(bAddr), irq, mFlag && mIen, err, mErr);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bAddr = a; bWd = d; bWe = 1'b1;
    @(negedge clk); #1;
    bWe = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    bAddr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  task automatic runFor(input int n);
    @(negedge clk); #1;
    run = 1'b1;
    repeat (n) @(negedge clk);
    #1 run = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    rdChk(4'h0, 32'hFFFF_FFFF, "R1 const");
    rdChk(4'h4, 32'hFFFF_FFFF, "R1 count");
    rdChk(4'h8, 32'h0, "R1 ctrl");
    rdChk(4'hC, 32'h0, "R1 capt");
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);

    // R4 constant vs count writes
    wr(4'h0, 32'd5);
    rdChk(4'h4, 32'hFFFF_FFFF, "R4 count untouched by const write");
    wr(4'h4, 32'd3);
    rdChk(4'h4, 32'd3, "R4 count load");
    rdChk(4'h0, 32'd5, "R4 const");

    // R2 each divider, three steps
    for (int c = 0; c <= 4; c++) begin
      wr(4'h4, 32'd1000);
      wr(4'h8, 32'h100 | c);
      runFor(3 * (4 << (2 * c)));
      rdChk(4'h4, 32'd997, $sformatf("R2 divider code %0d", c));
    end

    // R5 frozen while run low
    repeat (50) @(negedge clk);
    rdChk(4'h4, 32'd997, "R5 count held");

    // R3 reload at zero, R7 irq with enable
    wr(4'h0, 32'd7);
    wr(4'h4, 32'd0);
    wr(4'h8, 32'h120);
    runFor(3);
    rdChk(4'h4, 32'd0, "R3 no tick before 4 cycles");
    runFor(1);
    rdChk(4'h4, 32'd7, "R3 reloaded");
    rdChk(4'h8, 32'h120, "R3 flag set");
    chk("R7 irq high", {31'd0, irq}, 32'd1);

    // R6 flag clearing
    wr(4'h8, 32'h120);
    rdChk(4'h8, 32'h120, "R6 bit8=1 keeps flag");
    wr(4'h8, 32'h020);
    rdChk(4'h8, 32'h020, "R6 bit8=0 clears flag");
    chk("R7 irq low after clear", {31'd0, irq}, 32'd0);

    // R7 gating by enable
    wr(4'h4, 32'd0);
    wr(4'h8, 32'h100);
    runFor(4);
    rdChk(4'h8, 32'h100, "R7 flag set enable off");
    chk("R7 irq gated", {31'd0, irq}, 32'd0);
    wr(4'h8, 32'h120);
    @(negedge clk);
    chk("R7 irq after enable", {31'd0, irq}, 32'd1);

    // R8 read composition
    wr(4'h8, 32'h1A3);
    rdChk(4'h8, 32'h1A3, "R8 stored fields plus flag");
    chk("R8 no error on legal write", {31'd0, err}, 32'd0);

    // R10 capture register
    wr(4'hC, 32'h5A5A_1234);
    rdChk(4'hC, 32'h5A5A_1234, "R10 capture readback");

    // R9 reserved fields
    doReset();
    wr(4'h8, 32'h25);
    rdChk(4'h8, 32'h20, "R9 divider code 5 ignored");
    chk("R9 err code 5", {31'd0, err}, 32'd1);
    doReset();
    wr(4'h8, 32'h26);
    rdChk(4'h8, 32'h20, "R9 divider code 6 ignored");
    chk("R9 err code 6", {31'd0, err}, 32'd1);
    doReset();
    wr(4'h8, 32'h09);
    rdChk(4'h8, 32'h01, "R9 edge select ignored");
    chk("R9 err edge", {31'd0, err}, 32'd1);
    doReset();
    wr(4'h8, 32'h42);
    rdChk(4'h8, 32'h02, "R9 capture enable 1 ignored");
    chk("R9 err capture enable", {31'd0, err}, 32'd1);
    doReset();
    wr(4'h8, 32'h1003);
    rdChk(4'h8, 32'h03, "R9 upper bits ignored");
    chk("R9 err upper bits", {31'd0, err}, 32'd1);
    doReset();
    wr(4'h8, 32'h204);
    rdChk(4'h8, 32'h04, "R9 bit9 reads 0");
    chk("R9 bit9 legal with capture", {31'd0, err}, 32'd0);

    finish();
  end

endmodule